// File: doc/BRIEF.md
# Banked GPIO Direction and Data Register File

This block keeps the pin configuration for several 32-pin general-purpose I/O banks behind one word-addressed register port. Each bank has a direction word (a 1 makes the pin an input, a 0 turns its output driver on) and an output latch. Software normally changes the latch with atomic strobes: one address ORs a mask into the latch and another clears the masked bits. Bits that are 0 in the mask are left alone, so no read-modify-write is needed. A third address loads the whole latch at once. Pad levels are brought onto the GPIO clock through two flops per pin. The input word always shows these synchronized levels, including for pins that are currently driven as outputs.

All banks share one address map. Bank `b` begins at word `4 + 10*b`. Within a bank the word slots are: 0 direction, 1 output latch, 2 set strobe, 3 clear strobe, 4 synchronized input. Slots 5 to 9 are reserved for interrupt registers, which this block does not implement. Global pin `n` belongs to bank `n / 32`, bit `n % 32`, and uses the same position on the flat pad vectors.

The block has no sequencing state. Each bus cycle is decoded into a register kind (`REG_DIR`, `REG_OUT`, `REG_SET`, `REG_CLR`, `REG_IN` or `REG_RSV`). The request is then carried out at the next clock edge.

Top module: `gpio_banked_regs`

## Requirements
- R1: After reset every direction bit is 1, every output latch bit is 0, `pad_oe` and `pad_out` are all 0, and `bus_rdata` is 0.
- R2: A write to slot 0 of a bank loads that bank's direction word. From the following edge, `pad_oe` for each pin is the inverse of its direction bit: direction 0 gives `pad_oe` = 1.
- R3: A write to slot 2 sets every latch bit whose mask bit is 1 and leaves every latch bit whose mask bit is 0 unchanged.
- R4: A write to slot 3 clears every latch bit whose mask bit is 1 and leaves every latch bit whose mask bit is 0 unchanged.
- R5: A write to slot 1 replaces the whole output latch, and `pad_out` shows the latch from the next edge.
- R6: A read of slot 1, 2 or 3 returns the output latch. A read of slot 0 returns the direction word.
- R7: A read of slot 4 returns the pad levels after two synchronizer flops. A read sampled at the first or second edge after a pad change still returns the old level; a read sampled at the third edge returns the new one. This holds for output pins too.
- R8: Bank `b` decodes at word addresses `4+10*b` to `13+10*b` and drives pad bits `32*b` to `32*b+31`. A write to one bank leaves every other bank unchanged.
- R9: Reads of words below 4, of slots 5 to 9, and of any word beyond the last bank return 0. Writes to these words change no direction or latch bit.
- R10: `bus_rdata` is registered and updates only at an edge that samples a read. Write cycles and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | GPIO clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Word address |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data, valid the edge after a read |
| pad_in | input | 32*NUM_BANKS (64) | Raw pad levels |
| pad_out | output | 32*NUM_BANKS (64) | Output latch toward the pads |
| pad_oe | output | 32*NUM_BANKS (64) | Output driver enable toward the pads |

## Verification
Latch and direction writes show on `pad_out` and `pad_oe` one edge after the write is sampled. Read data is due one edge after the read is sampled. A pad change reaches the input word only at the third edge after it. The bench drives every request at a falling edge and updates its behavioural model at the rising edge. It compares all outputs at the next falling edge. The model keeps a queue of past pad samples, so that the input read always matches the level sampled two edges earlier. Directed reads placed at the first, second and third edges after a pad change check the stale-then-fresh window exactly.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
    localparam int BANK_PINS    = 32;
    localparam int BASE_WORD    = 4;
    localparam int STRIDE_WORDS = 10;

    typedef enum logic [2:0] {
        REG_DIR,
        REG_OUT,
        REG_SET,
        REG_CLR,
        REG_IN,
        REG_RSV
    } reg_kind_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regs_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [BANK_W-1:0] bank_sel,
    output reg_kind_e         kind
);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE_WORD);
    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(STRIDE_WORDS);
    localparam logic [ADDR_W-1:0] NB_A     = ADDR_W'(NUM_BANKS);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] bidx;
    logic [ADDR_W-1:0] slot;

    always_comb begin
        offset   = addr - BASE_A;
        bidx     = offset / STRIDE_A;
        slot     = offset - bidx * STRIDE_A;
        hit      = (addr >= BASE_A) && (bidx < NB_A);
        bank_sel = bidx[BANK_W-1:0];
        unique case (slot[3:0])
            4'd0:    kind = REG_DIR;
            4'd1:    kind = REG_OUT;
            4'd2:    kind = REG_SET;
            4'd3:    kind = REG_CLR;
            4'd4:    kind = REG_IN;
            default: kind = REG_RSV;
        endcase
    end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_regs_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_kind_e        kind,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] dir_d;
    logic [WIDTH-1:0] out_d;
    logic [WIDTH-1:0] in_sync;

    gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    always_comb begin
        dir_d = dir_q;
        out_d = out_q;
        if (wr_en) begin
            unique case (kind)
                REG_DIR: dir_d = wdata;
                REG_OUT: out_d = wdata;
                REG_SET: out_d = out_q | wdata;
                REG_CLR: out_d = out_q & ~wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            out_q <= '0;
        end else begin
            dir_q <= dir_d;
            out_q <= out_d;
        end
    end

    always_comb begin
        unique case (kind)
            REG_DIR:                   rd_word = dir_q;
            REG_OUT, REG_SET, REG_CLR: rd_word = out_q;
            REG_IN:                    rd_word = in_sync;
            default:                   rd_word = '0;
        endcase
    end

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == REG_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

    // R3
    set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == REG_SET) |=>
            ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));

    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == REG_CLR) |=> ((out_q & $past(wdata)) == '0));

    // R9
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && kind == REG_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_banked_regs.sv
module gpio_banked_regs
    import gpio_regs_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_en,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [BANK_PINS-1:0]           bus_wdata,
    output logic [BANK_PINS-1:0]           bus_rdata,
    input  logic [BANK_PINS*NUM_BANKS-1:0] pad_in,
    output logic [BANK_PINS*NUM_BANKS-1:0] pad_out,
    output logic [BANK_PINS*NUM_BANKS-1:0] pad_oe
);
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic              hit;
    logic [BANK_W-1:0] bank_sel;
    reg_kind_e         kind;
    logic [BANK_PINS-1:0] rd_words [NUM_BANKS];

    gpio_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_dec (
        .addr     (bus_addr),
        .hit      (hit),
        .bank_sel (bank_sel),
        .kind     (kind)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_PINS-1:0] dir_q;
        logic [BANK_PINS-1:0] out_q;
        logic                 wr_en;

        assign wr_en = bus_en && bus_we && hit && (bank_sel == BANK_W'(b));

        gpio_bank_regs #(.WIDTH(BANK_PINS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .kind    (kind),
            .wdata   (bus_wdata),
            .pad_in  (pad_in[b*BANK_PINS +: BANK_PINS]),
            .dir_q   (dir_q),
            .out_q   (out_q),
            .rd_word (rd_words[b])
        );

        assign pad_out[b*BANK_PINS +: BANK_PINS] = out_q;
        assign pad_oe[b*BANK_PINS +: BANK_PINS]  = ~dir_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_en && !bus_we) begin
            bus_rdata <= hit ? rd_words[bank_sel] : '0;
        end
    end

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en || bus_we) |=> $stable(bus_rdata));

    // R2
    oe_tracks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && hit && kind == REG_DIR && bank_sel == '0) |=>
            (pad_oe[BANK_PINS-1:0] == ~$past(bus_wdata)));
endmodule

// File: tb/tb_gpio_banked_regs.sv
module tb_gpio_banked_regs;
    localparam int NB = 2;
    localparam int W  = 32;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          bus_en = 0;
    logic          bus_we = 0;
    logic [7:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W*NB-1:0] pad_in = '0;
    logic [W*NB-1:0] pad_out;
    logic [W*NB-1:0] pad_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    gpio_banked_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Behavioural model
    logic [W-1:0]    m_dir [NB];
    logic [W-1:0]    m_out [NB];
    logic [W-1:0]    m_rdata;
    logic [W*NB-1:0] padq [$];

    function automatic void decode(input int a, output bit hit, output int b, output int r);
        hit = 0; b = 0; r = 0;
        if (a >= 4) begin
            b = (a - 4) / 10;
            r = (a - 4) % 10;
            hit = (b < NB) && (r < 5);
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin m_dir[i] = '1; m_out[i] = '0; end
            m_rdata = '0;
            padq = {'0, '0};
        end else begin
            bit h; int b; int r;
            logic [W*NB-1:0] synced;
            synced = padq[$-1];
            if (bus_en) begin
                decode(bus_addr, h, b, r);
                if (bus_we) begin
                    if (h) begin
                        case (r)
                            0: m_dir[b] = bus_wdata;
                            1: m_out[b] = bus_wdata;
                            2: m_out[b] = m_out[b] | bus_wdata;
                            3: m_out[b] = m_out[b] & ~bus_wdata;
                            default: ;
                        endcase
                    end
                end else if (!h) begin
                    m_rdata = '0;
                end else begin
                    case (r)
                        0: m_rdata = m_dir[b];
                        4: m_rdata = synced[b*W +: W];
                        default: m_rdata = m_out[b];
                    endcase
                end
            end
            padq.push_back(pad_in);
            if (padq.size() > 4) void'(padq.pop_front());
        end
    end

    task automatic check(input string req, input logic [W*NB-1:0] got, input logic [W*NB-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 pad_oe", pad_oe, {~m_dir[1], ~m_dir[0]});
            check("R5 pad_out", pad_out, {m_out[1], m_out[0]});
            check("R6 bus_rdata", {32'h0, bus_rdata}, {32'h0, m_rdata});
        end
    end

    task automatic wr(input int a, input logic [W-1:0] d);
        bus_en = 1; bus_we = 1; bus_addr = 8'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input int a, output logic [W-1:0] d);
        bus_en = 1; bus_we = 0; bus_addr = 8'(a);
        @(negedge clk);
        d = bus_rdata;
        bus_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        check("R1 rdata", {32'h0, bus_rdata}, '0);
        rd(4, v);  check("R1 dir reset", {32'h0, v}, 64'hFFFF_FFFF);
        // R2 direction
        wr(4, 32'hFFFF_0000);
        check("R2 oe low half", pad_oe, 64'h0000_0000_0000_FFFF);
        rd(4, v);  check("R6 dir read", {32'h0, v}, 64'hFFFF_0000);
        // R3 set strobes accumulate
        wr(6, 32'h0000_00F0);
        wr(6, 32'h0000_0F00);
        check("R3 set", pad_out, 64'h0FF0);
        // R4 clear strobe
        wr(7, 32'h0000_0030);
        check("R4 clr", pad_out, 64'h0FC0);
        // R6 latch visible at all three data slots
        rd(5, v);  check("R6 out slot", {32'h0, v}, 64'h0FC0);
        rd(6, v);  check("R6 set slot", {32'h0, v}, 64'h0FC0);
        rd(7, v);  check("R6 clr slot", {32'h0, v}, 64'h0FC0);
        // R5 direct load
        wr(5, 32'hA5A5_A5A5);
        check("R5 load", pad_out, 64'hA5A5_A5A5);
        // R10 rdata holds across writes and idle
        wr(6, 32'h1);
        @(negedge clk);
        check("R10 hold", {32'h0, bus_rdata}, 64'h0FC0);
        // R8 bank 1 independent
        wr(16, 32'h8000_0001);
        wr(14, 32'h0000_00FF);
        check("R8 bank1 out", pad_out, {32'h8000_0001, 32'hA5A5_A5A5});
        check("R8 bank1 oe", pad_oe, {32'hFFFF_FF00, 32'h0000_FFFF});
        rd(15, v); check("R8 bank1 read", {32'h0, v}, 64'h8000_0001);
        // R7 synchronizer latency, on output pins too
        pad_in = {32'h1234_5678, 32'h0000_FFFF};
        rd(8, v);  check("R7 stale edge1", {32'h0, v}, 64'h0);
        rd(8, v);  check("R7 stale edge2", {32'h0, v}, 64'h0);
        rd(8, v);  check("R7 fresh edge3", {32'h0, v}, 64'h0000_FFFF);
        rd(18, v); check("R7 bank1 input", {32'h0, v}, 64'h1234_5678);
        // R9 unmapped and reserved words
        wr(0, 32'hFFFF_FFFF);
        wr(9, 32'hFFFF_FFFF);
        wr(24, 32'h0);
        rd(0, v);  check("R9 below base", {32'h0, v}, 64'h0);
        rd(9, v);  check("R9 reserved slot", {32'h0, v}, 64'h0);
        rd(24, v); check("R9 beyond banks", {32'h0, v}, 64'h0);
        rd(4, v);  check("R9 dir unchanged", {32'h0, v}, 64'hFFFF_0000);
        check("R9 latch unchanged", pad_out, {32'h8000_0001, 32'hA5A5_A5A5});
        repeat (4) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule